// File: doc/BRIEF.md
# Streaming Color-to-Gray Pixel Converter

This block sits in a video pipeline between two streaming links and turns color pixels into gray ones, one pixel per beat. Each incoming 32-bit word carries three unsigned 8-bit channels. Blue is in bits 7:0, green in bits 15:8 and red in bits 23:16, and bits 31:24 are unused. For every pixel the block forms a rounded weighted luminance. It sends that value back out in all three channel positions, so a downstream consumer that expects three channels still receives a valid pixel.

Picture height and width come in as plain runtime inputs, up to 2000 in each dimension. The block keeps its own row and column counters. It rebuilds the start-of-frame flag (on TUSER) and the end-of-line flag (on TLAST) from those counters, and does not copy them from the input. It drops input until the first start-of-frame beat arrives. Whenever an input end-of-line flag disagrees with the programmed width, it sets a sticky error flag.

Back-pressure rules: a beat moves on either side only in a cycle where both valid and ready are high. While the output is valid and not ready, the output word and its sideband stay frozen and the input ready is held low. The input ready returns high in the same cycle that the output ready returns. When the output is accepted every cycle, the block takes one input beat per clock.

Top module: `gray_stream_conv`

## Requirements
- R1: The output gray value is (77*R + 150*G + 29*B + 128) >> 8, where B = s_tdata[7:0], G = s_tdata[15:8] and R = s_tdata[23:16].
- R2: m_tdata[7:0], m_tdata[15:8] and m_tdata[23:16] all carry the same gray value, m_tdata[31:24] is always zero, and s_tdata[31:24] has no effect on the output.
- R3: A kept beat accepted at clock edge k appears on the output with m_tvalid high right after edge k+1, provided nothing stalls. Before that edge m_tvalid is still low.
- R4: While m_tvalid is high and m_tready is low, m_tdata, m_tuser and m_tlast hold their values and s_tready is low.
- R5: m_tuser is high only on the output pixel at row 0, column 0 of a frame.
- R6: m_tlast is high on the output pixel at column cols-1 of every row, and on no other pixel.
- R7: Input beats accepted while no frame is open and without s_tuser are consumed (s_tready stays high) and produce no output. A frame closes after its last pixel (row rows-1, column cols-1), and the block then waits for the next s_tuser.
- R8: A kept input beat whose s_tlast differs from (column == cols-1) sets frame_err, and frame_err stays high until reset.
- R9: m_tid and m_tdest equal the s_tid and s_tdest of the pixel being sent.
- R10: Reset (rst_n low) clears the outputs: m_tvalid and frame_err go low and s_tready goes high.
- R11: An s_tuser beat in the middle of a frame restarts the counters, so that beat becomes row 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rows | input | 11 | Frame height in lines |
| cols | input | 11 | Frame width in pixels |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| s_tdata | input | 32 | Input pixel (B, G, R from low byte) |
| s_tuser | input | 1 | Input start of frame |
| s_tlast | input | 1 | Input end of line |
| s_tid | input | 1 | Input stream id |
| s_tdest | input | 1 | Input routing tag |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Output beat accepted |
| m_tdata | output | 32 | Gray value replicated in the low three bytes |
| m_tuser | output | 1 | Output start of frame |
| m_tlast | output | 1 | Output end of line |
| m_tid | output | 1 | Output stream id |
| m_tdest | output | 1 | Output routing tag |
| frame_err | output | 1 | Sticky line-length mismatch flag |

## Verification
A beat accepted at edge k is due on the output right after edge k+1. The bench therefore checks m_tvalid low at the falling edge after k and high, with the start-of-frame flag set, at the falling edge after k+1. The error flag is registered on the accepting edge, so it is checked at the falling edge that follows. Inputs change just after rising edges, and outputs are read at falling edges, where a valid-and-ready pair marks the transfer about to happen. Every result is therefore taken in a cycle where the design and the bench agree on it.

// File: rtl/gray_pkg.sv
package gray_pkg;
  localparam int CH_W  = 8;
  localparam int ACC_W = 2 * CH_W;
  localparam int WT_R  = 77;
  localparam int WT_G  = 150;
  localparam int WT_B  = 29;
  localparam int ROUND = 1 << (CH_W - 1);

  typedef struct packed {
    logic user;
    logic last;
    logic id;
    logic dest;
  } side_t;
endpackage

// File: rtl/gray_luma.sv
module gray_luma
  import gray_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [3*CH_W-1:0] bgr,
  output logic [CH_W-1:0]   gray
);
  logic [ACC_W-1:0] acc_d, acc_q;
  logic [CH_W-1:0]  gray_q;

  always_comb begin
    acc_d = ACC_W'(WT_B) * ACC_W'(bgr[CH_W-1:0])
          + ACC_W'(WT_G) * ACC_W'(bgr[2*CH_W-1:CH_W])
          + ACC_W'(WT_R) * ACC_W'(bgr[3*CH_W-1:2*CH_W])
          + ACC_W'(ROUND);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      gray_q <= '0;
    end else if (en) begin
      acc_q  <= acc_d;
      gray_q <= acc_q[ACC_W-1 -: CH_W];
    end
  end

  assign gray = gray_q;
endmodule

// File: rtl/gray_framer.sv
module gray_framer #(
  parameter int DIM_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIM_W-1:0] rows,
  input  logic [DIM_W-1:0] cols,
  input  logic             fire,
  input  logic             in_user,
  input  logic             in_last,
  output logic             keep,
  output logic             sof,
  output logic             eol,
  output logic             frame_err
);
  logic [DIM_W-1:0] col_q, row_q, pos_col, pos_row;
  logic             open_q, err_q, end_frame;

  always_comb begin
    keep      = in_user | open_q;
    pos_col   = in_user ? '0 : col_q;
    pos_row   = in_user ? '0 : row_q;
    eol       = (pos_col == cols - DIM_W'(1));
    sof       = (pos_col == '0) && (pos_row == '0);
    end_frame = eol && (pos_row == rows - DIM_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= '0;
      open_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (fire && keep) begin
      if (in_last != eol) err_q <= 1'b1;
      if (eol) begin
        col_q  <= '0;
        row_q  <= end_frame ? '0 : pos_row + DIM_W'(1);
        open_q <= !end_frame;
      end else begin
        col_q  <= pos_col + DIM_W'(1);
        row_q  <= pos_row;
        open_q <= 1'b1;
      end
    end
  end

  assign frame_err = err_q;
endmodule

// File: rtl/gray_stream_conv.sv
module gray_stream_conv
  import gray_pkg::*;
#(
  parameter int DIM_W  = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIM_W-1:0]  rows,
  input  logic [DIM_W-1:0]  cols,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tuser,
  input  logic              s_tlast,
  input  logic              s_tid,
  input  logic              s_tdest,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tuser,
  output logic              m_tlast,
  output logic              m_tid,
  output logic              m_tdest,
  output logic              frame_err
);
  localparam int PIX_W = 3 * CH_W;
  localparam int PAD_W = DATA_W - PIX_W;

  logic       advance, fire, keep, sof, eol;
  logic       st1_v, st2_v;
  side_t      st1_side, st2_side;
  logic [CH_W-1:0] gray;

  assign advance  = !st2_v || m_tready;
  assign s_tready = advance;
  assign fire     = s_tvalid && advance;

  gray_framer #(.DIM_W(DIM_W)) i_framer (
    .clk(clk), .rst_n(rst_n), .rows(rows), .cols(cols),
    .fire(fire), .in_user(s_tuser), .in_last(s_tlast),
    .keep(keep), .sof(sof), .eol(eol), .frame_err(frame_err)
  );

  gray_luma i_luma (
    .clk(clk), .rst_n(rst_n), .en(advance),
    .bgr(s_tdata[PIX_W-1:0]), .gray(gray)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_v    <= 1'b0;
      st2_v    <= 1'b0;
      st1_side <= '0;
      st2_side <= '0;
    end else if (advance) begin
      st1_v    <= fire && keep;
      st1_side <= '{user: sof, last: eol, id: s_tid, dest: s_tdest};
      st2_v    <= st1_v;
      st2_side <= st1_side;
    end
  end

  always_comb begin
    m_tdata = '0;
    for (int c = 0; c < 3; c++) m_tdata[c*CH_W +: CH_W] = gray;
    m_tdata[DATA_W-1 -: PAD_W] = '0;
  end

  assign m_tvalid = st2_v;
  assign m_tuser  = st2_side.user;
  assign m_tlast  = st2_side.last;
  assign m_tid    = st2_side.id;
  assign m_tdest  = st2_side.dest;
endmodule

// File: rtl/gray_stream_conv_chk.sv
module gray_stream_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        s_tvalid,
  input logic        s_tready,
  input logic        s_tuser,
  input logic        m_tvalid,
  input logic        m_tready,
  input logic [31:0] m_tdata,
  input logic        m_tuser,
  input logic        m_tlast,
  input logic        frame_err
);
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tuser) && $stable(m_tlast)));

  p_stall_blocks_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |-> !s_tready);

  p_top_byte_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (m_tdata[31:24] == 8'h00));

  p_channels_equal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> ((m_tdata[7:0] == m_tdata[15:8]) && (m_tdata[15:8] == m_tdata[23:16])));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);

  p_sof_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready && s_tuser) ##1 s_tready |=> (m_tvalid && m_tuser));
endmodule

bind gray_stream_conv gray_stream_conv_chk i_chk (
  .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready),
  .s_tuser(s_tuser), .m_tvalid(m_tvalid), .m_tready(m_tready),
  .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tlast(m_tlast),
  .frame_err(frame_err)
);

// File: tb/test_gray_stream_conv.sv
module test_gray_stream_conv;
  localparam time PERIOD = 10ns;
  localparam logic [39:0] VEC [8] = '{
    40'h0000000000, 40'hFFFFFFFFFF, 40'h00FF00004D, 40'h0000FF0095,
    40'h000000FF1D, 40'h1234567850, 40'hAB80808080, 40'h001020301D
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [10:0] rows = 11'd2, cols = 11'd4;
  logic s_tvalid = 1'b0, s_tuser = 1'b0, s_tlast = 1'b0, s_tid = 1'b0, s_tdest = 1'b0;
  logic [31:0] s_tdata = '0;
  logic m_tready = 1'b1;
  logic s_tready, m_tvalid, m_tuser, m_tlast, m_tid, m_tdest, frame_err;
  logic [31:0] m_tdata;

  int nchk = 0, nerr = 0, ncap = 0;
  logic [31:0] cap_data [64];
  logic [3:0]  cap_side [64];

  always #(PERIOD/2) clk = ~clk;

  gray_stream_conv i_gray_stream_conv (
    .clk(clk), .rst_n(rst_n), .rows(rows), .cols(cols),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
    .s_tuser(s_tuser), .s_tlast(s_tlast), .s_tid(s_tid), .s_tdest(s_tdest),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
    .m_tuser(m_tuser), .m_tlast(m_tlast), .m_tid(m_tid), .m_tdest(m_tdest),
    .frame_err(frame_err)
  );

  always @(negedge clk) begin
    if (rst_n && m_tvalid && m_tready && ncap < 64) begin
      cap_data[ncap] = m_tdata;
      cap_side[ncap] = {m_tuser, m_tlast, m_tid, m_tdest};
      ncap++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] d, input logic u, input logic l, input logic id, input logic de);
    s_tvalid = 1'b1; s_tdata = d; s_tuser = u; s_tlast = l; s_tid = id; s_tdest = de;
  endtask

  task automatic wait_acc();
    logic acc;
    do begin
      @(negedge clk); acc = s_tready;
      @(posedge clk); #1;
    end while (!acc);
  endtask

  task automatic send(input logic [31:0] d, input logic u, input logic l);
    drive(d, u, l, 1'b0, 1'b0);
    wait_acc();
  endtask

  task automatic idle(input int n);
    s_tvalid = 1'b0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  function automatic logic [31:0] rep(input logic [7:0] g);
    return {8'h00, g, g, g};
  endfunction

  initial begin
    #(PERIOD * 20000);
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int base;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset m_tvalid", 32'(m_tvalid), 0);
    chk("R10 reset frame_err", 32'(frame_err), 0);
    chk("R10 reset s_tready", 32'(s_tready), 1);
    @(posedge clk); #1;

    // Vector table: one 2x4 frame, back to back (R1 R2 R5 R6 R9)
    base = ncap;
    for (int i = 0; i < 8; i++) begin
      drive(VEC[i][39:8], i == 0, (i % 4) == 3, i[0], i[1]);
      wait_acc();
    end
    idle(5);
    chk("R3 one beat per clock count", 32'(ncap - base), 8);
    for (int i = 0; i < 8; i++) begin
      chk("R1 R2 gray word", cap_data[base+i], rep(VEC[i][7:0]));
      chk("R5 sof flag", 32'(cap_side[base+i][3]), 32'(i == 0));
      chk("R6 eol flag", 32'(cap_side[base+i][2]), 32'((i % 4) == 3));
      chk("R9 id/dest", 32'(cap_side[base+i][1:0]), 32'({i[0], i[1]}));
    end
    chk("R8 no error on clean frame", 32'(frame_err), 0);

    // Latency (R3) then back-pressure (R4), one-line frame
    rows = 11'd1;
    base = ncap;
    send(VEC[4][39:8], 1'b1, 1'b0);
    s_tvalid = 1'b0;
    @(negedge clk);
    chk("R3 not valid after first edge", 32'(m_tvalid), 0);
    @(posedge clk); #1;
    @(negedge clk);
    chk("R3 valid after second edge", 32'(m_tvalid), 1);
    chk("R3 R5 sof on first pixel", 32'(m_tuser), 1);
    @(posedge clk); #1;
    m_tready = 1'b0;
    send(VEC[5][39:8], 1'b0, 1'b0);
    send(VEC[6][39:8], 1'b0, 1'b0);
    drive(VEC[7][39:8], 1'b0, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R4 input blocked", 32'(s_tready), 0);
      chk("R4 output held", m_tdata, rep(VEC[5][7:0]));
      chk("R4 valid held", 32'(m_tvalid), 1);
      @(posedge clk); #1;
    end
    m_tready = 1'b1;
    wait_acc();
    idle(5);
    chk("R4 no beat lost or duplicated", 32'(ncap - base), 4);
    for (int i = 0; i < 4; i++) begin
      chk("R4 order kept", cap_data[base+i], rep(VEC[4+i][7:0]));
      chk("R6 eol at cols-1", 32'(cap_side[base+i][2]), 32'(i == 3));
    end

    // Discard before start of frame (R7)
    base = ncap;
    send(VEC[2][39:8], 1'b0, 1'b0);
    send(VEC[3][39:8], 1'b0, 1'b1);
    send(VEC[5][39:8], 1'b0, 1'b0);
    idle(5);
    chk("R7 dropped beats give no output", 32'(ncap - base), 0);
    chk("R7 dropped beats raise no error", 32'(frame_err), 0);

    // Mid-frame restart (R11)
    base = ncap;
    send(VEC[0][39:8], 1'b1, 1'b0);
    send(VEC[1][39:8], 1'b0, 1'b0);
    send(VEC[2][39:8], 1'b1, 1'b0);
    send(VEC[3][39:8], 1'b0, 1'b0);
    send(VEC[4][39:8], 1'b0, 1'b0);
    send(VEC[5][39:8], 1'b0, 1'b1);
    idle(5);
    chk("R11 restart count", 32'(ncap - base), 6);
    for (int i = 0; i < 6; i++) begin
      chk("R11 sof after restart", 32'(cap_side[base+i][3]), 32'(i == 0 || i == 2));
      chk("R11 eol after restart", 32'(cap_side[base+i][2]), 32'(i == 5));
    end
    chk("R11 no error", 32'(frame_err), 0);

    // Early end of line sets a sticky error (R8)
    send(VEC[0][39:8], 1'b1, 1'b0);
    send(VEC[1][39:8], 1'b0, 1'b1);
    s_tvalid = 1'b0;
    @(negedge clk);
    chk("R8 early tlast flagged", 32'(frame_err), 1);
    @(posedge clk); #1;
    send(VEC[2][39:8], 1'b0, 1'b0);
    send(VEC[3][39:8], 1'b0, 1'b1);
    idle(3);
    @(negedge clk);
    chk("R8 error stays set", 32'(frame_err), 1);
    rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset clears error", 32'(frame_err), 0);
    chk("R10 reset clears valid", 32'(m_tvalid), 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule